// File: doc/BRIEF.md
# Strobed-Latch 4-to-16 Line Decoder

This block holds a small binary code in a level-sensitive input latch and turns the held code into a bank of one-hot select lines. While the strobe input is high the latch is transparent and the outputs follow the code inputs. When the strobe falls the latch freezes, and the outputs keep decoding the code that was present just before the fall, whatever the code inputs do afterwards. The default is a 4-bit code and sixteen select lines. The block suits address decoding, display digit selection and control decoding where the code source does not stay valid.

An inhibit input acts only on the outputs. It forces every line to the deselected level at once and needs no clock. The latch keeps working while inhibit is high, so a strobe pulse during inhibit still loads a new code. Releasing inhibit shows the decode of whatever code is then held. The parameter `ACTIVE_LOW` is fixed at elaboration and sets the output polarity. When it is 0, the selected line is 1 and the others are 0. When it is 1, the selected line is 0 and the others are 1.

Top module: `latched_line_decoder`

## Requirements
- R1: While `strobe` is 1 and `inhibit` is 0, the line selected by `sel_out` follows `code_in` with no clock.
- R2: When `strobe` falls from 1 to 0, the code present just before the fall is held. Changes on `code_in` while `strobe` is 0 do not change `sel_out`.
- R3: `code_in[0]` is the least significant bit. Code value n selects line `sel_out[n]`, and all sixteen codes 0 to 15 are legal.
- R4: While `inhibit` is 0, exactly one line of `sel_out` is at the selected level.
- R5: While `inhibit` is 1, every line of `sel_out` is at the deselected level, whatever `code_in` and `strobe` are doing.
- R6: When `inhibit` goes from 1 to 0, `sel_out` shows the decode of the code currently held. The held code is not lost during inhibit.
- R7: With `ACTIVE_LOW` = 0 the selected line is 1 and inhibit drives all lines to 0. With `ACTIVE_LOW` = 1 the selected line is 0 and inhibit drives all lines to 1.
- R8: A strobe pulse while `inhibit` is 1 loads the latch. The new code appears on `sel_out` once inhibit is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_in | input | CODE_W (4) | Binary code to be latched and decoded; bit 0 is the LSB |
| strobe | input | 1 | Latch enable: 1 = transparent, 1-to-0 edge holds the code |
| inhibit | input | 1 | 1 forces every select line to the deselected level |
| sel_out | output | 2**CODE_W (16) | One-hot select lines; polarity set by ACTIVE_LOW |

## Verification
The immediate assertions re-evaluate whenever an input settles. They check the parts of the behaviour that the present inputs determine: all lines deselected under inhibit, exactly one selected line otherwise with the right polarity, a one-hot internal decode, and the selected index matching `code_in` while the latch is transparent. Behaviour that depends on history can only be shown by the bench's ordered scenarios. This covers holding the code across a strobe fall while the inputs change, keeping the held code through inhibit, loading during inhibit, and the full sweep of sixteen codes run against an active-high instance and an active-low instance together.

// File: rtl/lat_dec_pkg.sv
`timescale 1ns/1ps
package lat_dec_pkg;
   localparam int MAX_CODE_W = 8;

   function automatic int line_count(input int code_w);
      return 1 << code_w;
   endfunction
endpackage

// File: rtl/code_latch.sv
`timescale 1ns/1ps
module code_latch #(
   parameter int CODE_W = 4
) (
   input  logic [CODE_W-1:0] d,
   input  logic              en,
   output logic [CODE_W-1:0] q
);
   // Level-sensitive hold: transparent while en is high.
   always_latch begin
      if (en) q = d;
   end
endmodule

// File: rtl/onehot_decoder.sv
`timescale 1ns/1ps
module onehot_decoder #(
   parameter int CODE_W = 4,
   parameter int LINES  = 16
) (
   input  logic [CODE_W-1:0] code,
   output logic [LINES-1:0]  hot
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign hot[i] = (code == CODE_W'(i));
   end

   // R3 / R4: the raw decode is always one-hot
   always_comb begin
      a_r4_decode_onehot: assert ($onehot(hot))
         else $error("decoder output not one-hot: %b", hot);
   end
endmodule

// File: rtl/polarity_stage.sv
`timescale 1ns/1ps
module polarity_stage #(
   parameter int LINES      = 16,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic [LINES-1:0] hot,
   input  logic             inhibit,
   output logic [LINES-1:0] lines
);
   localparam logic [LINES-1:0] IDLE = ACTIVE_LOW ? {LINES{1'b1}} : {LINES{1'b0}};

   if (ACTIVE_LOW) begin : g_low
      assign lines = inhibit ? IDLE : ~hot;
   end else begin : g_high
      assign lines = inhibit ? IDLE : hot;
   end

   // R5 / R7: inhibit drives every line to the deselected level
   always_comb begin
      if (inhibit) begin
         a_r5_inhibit_idle: assert (lines == IDLE)
            else $error("inhibit active but lines=%b", lines);
      end
   end

   // R4 / R7: exactly one line at the selected level when not inhibited
   always_comb begin
      if (!inhibit) begin
         a_r7_one_selected: assert ($countones(lines ^ IDLE) == 1)
            else $error("selected-line count wrong: %b", lines);
      end
   end
endmodule

// File: rtl/latched_line_decoder.sv
`timescale 1ns/1ps
module latched_line_decoder #(
   parameter int CODE_W     = 4,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic [CODE_W-1:0]                         code_in,
   input  logic                                      strobe,
   input  logic                                      inhibit,
   output logic [lat_dec_pkg::line_count(CODE_W)-1:0] sel_out
);
   import lat_dec_pkg::*;

   localparam int LINES = line_count(CODE_W);

   if (CODE_W < 1 || CODE_W > MAX_CODE_W) begin : g_bad_width
      $error("CODE_W out of range");
   end

   logic [CODE_W-1:0] held_code;
   logic [LINES-1:0]  hot;

   code_latch #(.CODE_W(CODE_W)) u_latch (
      .d   (code_in),
      .en  (strobe),
      .q   (held_code)
   );

   onehot_decoder #(.CODE_W(CODE_W), .LINES(LINES)) u_dec (
      .code (held_code),
      .hot  (hot)
   );

   polarity_stage #(.LINES(LINES), .ACTIVE_LOW(ACTIVE_LOW)) u_out (
      .hot     (hot),
      .inhibit (inhibit),
      .lines   (sel_out)
   );

   // R1 / R3: transparent latch, so code_in picks the active line directly
   logic [LINES-1:0] active;
   assign active = ACTIVE_LOW ? ~sel_out : sel_out;

   always_comb begin
      if (strobe && !inhibit) begin
         a_r1_transparent_select: assert (active[code_in])
            else $error("line %0d not selected while transparent", code_in);
      end
   end
endmodule

// File: tb/latched_line_decoder_bench.sv
`timescale 1ns/1ps
module latched_line_decoder_bench;
   logic       clk = 1'b0;
   logic [3:0] code_in = '0;
   logic       strobe = 1'b1;
   logic       inhibit = 1'b1;
   logic [15:0] sel_hi, sel_lo;
   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   latched_line_decoder #(.CODE_W(4), .ACTIVE_LOW(1'b0)) u_latched_line_decoder (
      .code_in (code_in), .strobe (strobe), .inhibit (inhibit), .sel_out (sel_hi));
   latched_line_decoder #(.CODE_W(4), .ACTIVE_LOW(1'b1)) u_latched_line_decoder_lo (
      .code_in (code_in), .strobe (strobe), .inhibit (inhibit), .sel_out (sel_lo));

   // entry: {req[3:0], code[3:0], strobe, inhibit, expected active-high lines[15:0]}
   localparam logic [25:0] VEC [0:11] = '{
      {4'd1, 4'd3,  1'b1, 1'b0, 16'h0008},
      {4'd1, 4'd9,  1'b1, 1'b0, 16'h0200},
      {4'd2, 4'd9,  1'b0, 1'b0, 16'h0200},
      {4'd2, 4'd4,  1'b0, 1'b0, 16'h0200},
      {4'd2, 4'd15, 1'b0, 1'b0, 16'h0200},
      {4'd5, 4'd15, 1'b0, 1'b1, 16'h0000},
      {4'd5, 4'd2,  1'b1, 1'b1, 16'h0000},
      {4'd8, 4'd2,  1'b0, 1'b1, 16'h0000},
      {4'd8, 4'd7,  1'b0, 1'b0, 16'h0004},
      {4'd3, 4'd0,  1'b1, 1'b0, 16'h0001},
      {4'd3, 4'd15, 1'b1, 1'b0, 16'h8000},
      {4'd2, 4'd15, 1'b0, 1'b0, 16'h8000}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // both polarities: R7 says the active-low lines are the complement
   task automatic check_both(input string req, input logic [15:0] exp_hi);
      check({req, " hi"}, sel_hi, exp_hi);
      check({req, " lo R7"}, sel_lo, ~exp_hi);
   endtask

   task automatic drive(input logic [3:0] c, input logic s, input logic i);
      @(posedge clk);
      code_in = c; strobe = s; inhibit = i;
      @(negedge clk);
   endtask

   initial begin
      // reset condition: inhibit held high, R5 / R7
      drive(4'd6, 1'b1, 1'b1);
      check_both("R5 reset", 16'h0000);

      // table walk: R1 R2 R3 R5 R6 R8
      for (int k = 0; k < 12; k++) begin
         drive(VEC[k][21:18], VEC[k][17], VEC[k][16]);
         check_both($sformatf("R%0d vec%0d", VEC[k][25:22], k), VEC[k][15:0]);
      end

      // R3 / R4: every code, transparent
      for (int n = 0; n < 16; n++) begin
         drive(4'(n), 1'b1, 1'b0);
         check_both($sformatf("R3 code%0d", n), 16'h0001 << n);
      end

      // R2: hold code 5, sweep inputs while strobe low
      drive(4'd5, 1'b1, 1'b0);
      drive(4'd5, 1'b0, 1'b0);
      for (int n = 0; n < 16; n++) begin
         drive(4'(n), 1'b0, 1'b0);
         check_both("R2 hold", 16'h0020);
      end

      // R6: inhibit with strobe low, then release restores code 5
      drive(4'd12, 1'b0, 1'b1);
      check_both("R5 inhibit", 16'h0000);
      drive(4'd12, 1'b0, 1'b0);
      check_both("R6 restore", 16'h0020);

      // R8: load 11 during inhibit, release shows 11
      drive(4'd11, 1'b1, 1'b1);
      check_both("R5 inhibit strobe", 16'h0000);
      drive(4'd1, 1'b0, 1'b1);
      drive(4'd1, 1'b0, 1'b0);
      check_both("R8 load under inhibit", 16'h0800);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule